// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one byte from a local sender into an asynchronous serial frame on a single output line. The sender waits until `finished` is high. It then presents a byte on `wdata` together with the parity and stop-length settings, and pulses `send`. The block captures the byte and the settings in that cycle and drops `finished`. It then shifts out a start bit, the data bits least significant first, an optional parity bit and the stop time. When the stop time is over it raises `finished` again. A rising `finished` can be used as an interrupt source.

Bit timing comes from `tick16`, a one-cycle strobe at sixteen times the baud rate that is generated outside the block. A data, start or parity bit lasts 16 strobes. The stop time lasts 16, 24 or 32 strobes. The line is the least significant bit of a parallel-load shift register, so it comes straight from a flop. The control is a five-state machine:

- `ST_IDLE` to `ST_START` on an accepted send.
- `ST_START` to `ST_DATA` after 16 strobes.
- `ST_DATA` to itself after 16 strobes while data bits remain.
- `ST_DATA` to `ST_PARITY` after the last data bit when parity is on, or to `ST_STOP` when it is off.
- `ST_PARITY` to `ST_STOP` after 16 strobes.
- `ST_STOP` to `ST_IDLE` when the stop time is over.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever reset is applied (also in the middle of a frame), `tx` is 1 and `finished` is 1.
- R2: `send` high while `finished` is high is accepted at that clock edge: `wdata`, `par_mode` and `stop_len` are captured, and `finished` reads 0 from the next cycle on.
- R3: The start bit is 0 and stays on the line until the 16th `tick16` strobe after acceptance has been consumed. A strobe in the acceptance cycle itself is not counted.
- R4: The data bits follow the start bit least significant bit first, each for 16 strobes. `tx` changes only on a clock edge that consumes a strobe or accepts a send.
- R5: `par_mode` 1 selects even parity, so the data and parity bit together hold an even number of ones. `par_mode` 2 selects odd parity. The parity bit lasts 16 strobes and follows the last data bit.
- R6: `par_mode` 3 sends a parity bit fixed at 0, and `par_mode` 4 sends one fixed at 1.
- R7: `par_mode` 0 and codes 5 to 7 send no parity bit, so the stop time follows the last data bit directly.
- R8: The stop time holds `tx` at 1. `stop_len` 0 gives 16 strobes (one bit), 1 gives 24 strobes (one and a half bits), and 2 or 3 give 32 strobes (two bits).
- R9: `finished` stays 0 for the whole frame and returns to 1 at the clock edge that consumes the last strobe of the stop time.
- R10: `send` while `finished` is 0 has no effect: the frame in progress is unchanged, and no further frame follows it.
- R11: Changes to `wdata`, `par_mode` and `stop_len` after acceptance do not alter the frame in progress.
- R12: If `send` is held high across the end of a frame, `finished` is high for exactly one cycle, and the next frame is accepted at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle strobe at 16 times the baud rate |
| wdata | input | 8 | Byte to transmit |
| send | input | 1 | Start request, honoured only while `finished` is high |
| par_mode | input | 3 | 0 none, 1 even, 2 odd, 3 fixed 0, 4 fixed 1, 5 to 7 none |
| stop_len | input | 2 | 0 one bit, 1 one and a half bits, 2 and 3 two bits |
| tx | output | 1 | Serial line, idle high, registered |
| finished | output | 1 | High when a new byte may be sent |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a send request and the completion of the stop time. The bench holds `send` high across the end of a frame. It then checks that `finished` rises for exactly one cycle and that the second frame is cycle-exact. The second pair is a strobe and an acceptance in the same cycle. The strobe generator runs freely against the send timing, and the number of start-bit strobes seen on the line shows whether that strobe was counted. A send pulse that lands while a frame is in flight is judged by the unchanged frame on the line and by a quiet line afterwards.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    localparam logic [2:0] PM_NONE = 3'd0;
    localparam logic [2:0] PM_EVEN = 3'd1;
    localparam logic [2:0] PM_ODD  = 3'd2;
    localparam logic [2:0] PM_ZERO = 3'd3;
    localparam logic [2:0] PM_ONE  = 3'd4;

    function automatic logic parity_on(input logic [2:0] mode);
        return (mode == PM_EVEN) || (mode == PM_ODD) ||
               (mode == PM_ZERO) || (mode == PM_ONE);
    endfunction

    // The parity bit for a given data word; 1 when parity is off, so the
    // slot merges with the stop time.
    function automatic logic parity_value(input logic [2:0] mode, input logic data_xor);
        logic v;
        unique case (mode)
            PM_EVEN: v = data_xor;
            PM_ODD:  v = ~data_xor;
            PM_ZERO: v = 1'b0;
            PM_ONE:  v = 1'b1;
            default: v = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/uart_tx_tickcnt.sv
module uart_tx_tickcnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          bit_done
);
    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end   = (cnt == limit - CW'(1));
    assign bit_done = run && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            if (at_end) cnt <= '0;
            else        cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/uart_tx_piso.sv
module uart_tx_piso #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         line
);
    logic [W-1:0] sr;

    assign line = sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {1'b1, sr[W-1:1]};
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick16,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 send,
    input  logic [2:0]           par_mode,
    input  logic [1:0]           stop_len,
    output logic                 tx,
    output logic                 finished
);
    localparam int SW = DATA_BITS + 2;
    localparam int CW = $clog2(2 * OVS + 1);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    tx_state_e     state, state_n;
    logic          finished_q;
    logic          par_en_q;
    logic [1:0]    stop_q;
    logic [BW-1:0] bit_idx;
    logic [CW-1:0] limit;
    logic          accept;
    logic          bit_done;
    logic          shift;
    logic          par_bit;
    logic [SW-1:0] frame;

    assign accept   = send && finished_q;
    assign finished = finished_q;

    // Start bit in the LSB; the top slot holds parity or an early stop 1.
    assign par_bit = parity_value(par_mode, ^wdata);
    assign frame   = {par_bit, wdata, 1'b0};

    always_comb begin
        if (state == ST_STOP) begin
            unique case (stop_q)
                2'd0:    limit = CW'(OVS);
                2'd1:    limit = CW'(OVS + OVS / 2);
                default: limit = CW'(2 * OVS);
            endcase
        end else begin
            limit = CW'(OVS);
        end
    end

    assign shift = bit_done &&
                   ((state == ST_START) || (state == ST_DATA) || (state == ST_PARITY));

    uart_tx_tickcnt #(.CW(CW)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .run      (state != ST_IDLE),
        .tick     (tick16),
        .limit    (limit),
        .bit_done (bit_done)
    );

    uart_tx_piso #(.W(SW)) u_sr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (frame),
        .shift    (shift),
        .line     (tx)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (accept)   state_n = ST_START;
            ST_START:  if (bit_done) state_n = ST_DATA;
            ST_DATA:   if (bit_done && bit_idx == BW'(DATA_BITS - 1))
                           state_n = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_n = ST_STOP;
            ST_STOP:   if (bit_done) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // State register and frame settings
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            par_en_q <= 1'b0;
            stop_q   <= 2'd0;
            bit_idx  <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                par_en_q <= parity_on(par_mode);
                stop_q   <= stop_len;
                bit_idx  <= '0;
            end else if (state == ST_DATA && bit_done) begin
                bit_idx  <= bit_idx + BW'(1);
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            finished_q <= 1'b1;
        end else if (accept) begin
            finished_q <= 1'b0;
        end else if (state == ST_STOP && bit_done) begin
            finished_q <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic tick16,
    input logic send,
    input logic tx,
    input logic finished
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        finished |-> tx);                                            // R1
    AST_SEND_DROPS_FIN: assert property (@(posedge clk) disable iff (rst)
        (finished && send) |=> !finished);                           // R2
    AST_FIN_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(finished) |-> $past(send));                            // R10
    AST_LINE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!tick16 && !(send && finished)) |=> $stable(tx));           // R4
    AST_FIN_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(finished) |-> $past(tick16));                          // R9
    AST_STOP_IS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(finished) |-> (tx && $past(tx)));                      // R8
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick16   (tick16),
    .send     (send),
    .tx       (tx),
    .finished (finished)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       send = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic [1:0] stop_len = 2'd0;
    logic       tx;
    logic       finished;
    logic [1:0] div = 2'd0;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    // Free-running strobe, one clock in three
    always @(posedge clk) begin
        div    <= (div == 2'd2) ? 2'd0 : div + 2'd1;
        tick16 <= (div == 2'd2);
    end

    uart_frame_tx u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .wdata(wdata), .send(send),
        .par_mode(par_mode), .stop_len(stop_len), .tx(tx), .finished(finished)
    );

    // {data, par_mode, stop_len, expected parity bit}
    localparam logic [13:0] VEC [8] = '{
        {8'h55, 3'd1, 2'd0, 1'b0},   // R5 even
        {8'h57, 3'd1, 2'd1, 1'b1},   // R5 even, R8 1.5 stop
        {8'h57, 3'd2, 2'd2, 1'b0},   // R5 odd, R8 2 stop
        {8'h00, 3'd2, 2'd0, 1'b1},   // R5 odd on zero data
        {8'hA3, 3'd0, 2'd0, 1'b0},   // R7 none
        {8'hFF, 3'd3, 2'd2, 1'b0},   // R6 fixed 0
        {8'h00, 3'd4, 2'd1, 1'b1},   // R6 fixed 1
        {8'h81, 3'd6, 2'd3, 1'b0}    // R7 code 6, R8 code 3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int stop_ticks(input logic [1:0] sl);
        if (sl == 2'd0) return 16;
        if (sl == 2'd1) return 24;
        return 32;
    endfunction

    // Accept at the next edge; leaves the bench at the negedge after it.
    task automatic do_send(input logic [7:0] d, input logic [2:0] pm,
                           input logic [1:0] sl, input bit hold);
        @(negedge clk);
        while (!finished) @(negedge clk);
        wdata = d; par_mode = pm; stop_len = sl; send = 1'b1;
        @(negedge clk);
        check(finished == 1'b0, "R2 finished after send", finished, 0);
        if (!hold) send = 1'b0;
    endtask

    // Called at the negedge after acceptance; returns at the negedge after
    // the edge that consumed the last stop strobe.
    task automatic watch(input logic [7:0] d, input logic [2:0] pm, input logic [1:0] sl,
                         input logic pbit, input bit poke, input bit busy_send, input bit hold);
        bit   pon = (pm >= 3'd1 && pm <= 3'd4);
        int   total = 16 * (9 + (pon ? 1 : 0)) + stop_ticks(sl);
        int   n = 0;
        int   c = 0;
        int   bad_at = -1;
        logic bad_val = 1'b0;
        logic exp_val = 1'b1;
        bit   fin_ok = 1'b1;
        while (n < total && c < 5000) begin
            if (poke && c == 30) begin
                wdata = ~d; par_mode = 3'd4; stop_len = 2'd0;             // R11
            end
            if (busy_send && c == 60) send = 1'b1;                        // R10
            if (busy_send && c == 61) send = 1'b0;
            if (tick16) begin
                int idx = n / 16;
                logic e;
                n++;
                if (idx == 0)              e = 1'b0;
                else if (idx <= 8)         e = d[idx-1];
                else if (idx == 9 && pon)  e = pbit;
                else                       e = 1'b1;
                if (tx !== e && bad_at < 0) begin
                    bad_at = n; bad_val = tx; exp_val = e;
                end
                if (finished !== 1'b0) fin_ok = 1'b0;
            end
            c++;
            @(negedge clk);
        end
        check(bad_at < 0, "R3/R4/R5/R6/R7/R8 line per strobe", bad_val, exp_val);
        check(fin_ok, "R9 finished low in frame", 1, 0);
        check(finished === 1'b1 && tx === 1'b1, "R9 finished after stop",
              {finished, tx}, 2'b11);
        if (!hold) send = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx === 1'b1 && finished === 1'b1, "R1 reset state", {tx, finished}, 2'b11);

        for (int i = 0; i < 8; i++) begin
            do_send(VEC[i][13:6], VEC[i][5:3], VEC[i][2:1], 1'b0);
            watch(VEC[i][13:6], VEC[i][5:3], VEC[i][2:1], VEC[i][0], 1'b0, 1'b0, 1'b0);
        end

        // R11: settings and data altered mid-frame
        do_send(8'h3C, 3'd2, 2'd2, 1'b0);
        watch(8'h3C, 3'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);

        // R10: send pulse while busy, then line must stay quiet
        do_send(8'hC6, 3'd1, 2'd1, 1'b0);
        watch(8'hC6, 3'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        begin
            bit quiet = 1'b1;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (tx !== 1'b1 || finished !== 1'b1) quiet = 1'b0;
            end
            check(quiet, "R10 no extra frame", 0, 1);
        end

        // R12: send held across the end of a frame
        do_send(8'h96, 3'd0, 2'd0, 1'b1);
        watch(8'h96, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check(finished === 1'b0, "R12 next frame accepted after one cycle", finished, 0);
        send = 1'b0;
        watch(8'h96, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R1: reset in the middle of a frame
        do_send(8'h00, 3'd1, 2'd2, 1'b0);
        repeat (90) @(negedge clk);
        check(tx === 1'b0, "R1 frame under way before reset", tx, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx === 1'b1 && finished === 1'b1, "R1 reset mid-frame", {tx, finished}, 2'b11);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule